// File: doc/BRIEF.md
# Windowed Backplane Access Splitter

This block sits between a requester that wants to reach a 32-bit backplane address space and a serial command master that can only address a 15-bit offset inside a movable window. The window base is set through three one-byte registers on the backplane function. The block keeps a cached copy of the window base and, for every chunk it emits, writes only those base bytes that differ from the cache. It then issues the data command for that chunk.

A request carries a start address, a byte length, a direction and a bulk/single marker. Long transfers are cut into chunks so that no chunk crosses a 32 KiB window edge and no chunk carries more than 64 bytes. A single (register-style) access of exactly four bytes is marked with the 32-bit access flag in the bus address. The data bytes themselves stream directly between the requester and the serial master. The chunk lengths announced here tell the serial master how many bytes belong to each command. All commands target the backplane function, so no function number is carried.

Top module: `window_split`

## Requirements
- R1: After reset `busy` is 0, `req_ready` is 1 and `cmd_valid` is 0. The cached window base starts at 0xAAAAAAAA, so the first access writes all three window bytes.
- R2: Window register writes are issued only for base bytes that differ from the cache, in the order high, mid, low, back to back and before the chunk's data command. Each is a write with length 1, `cmd_wdata` holding the byte. The bus addresses are 0x1000C for base bits 31:24, 0x1000B for bits 23:16 and 0x1000A for bits 15:8.
- R3: A data command has `cmd_write` equal to the request direction and `cmd_wdata` 0. Its `cmd_addr` bits 14:0 carry the in-window offset (address bits 14:0), and its `cmd_len` is the chunk length.
- R4: Each chunk length is the smallest of the bytes remaining, 64, and 0x8000 minus the offset. The next chunk starts at the address advanced by that length.
- R5: Bit 15 of `cmd_addr` on a data command is 1 only for a single (`req_bulk`=0) request of exactly 4 bytes. It is 0 for bulk requests of any length.
- R6: A bulk request with address bits 1:0 nonzero is rejected. `req_err` pulses for one cycle in the cycle after acceptance, no command is issued and `busy` stays 0. Single requests may be unaligned.
- R7: `busy` rises in the cycle after a request is accepted and falls in the cycle after the last data command is accepted. `req_ready` is the inverse of `busy`.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, all command fields hold their values.
- R9: A request of length 0 issues no command and leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Backplane start address |
| req_len | input | LEN_W (16) | Length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bulk | input | 1 | 1 = bulk transfer, 0 = single register access |
| req_err | output | 1 | One-cycle pulse: bulk start address misaligned |
| busy | output | 1 | Request in progress |
| cmd_valid | output | 1 | Command to serial master is valid |
| cmd_ready | input | 1 | Serial master accepts the command |
| cmd_write | output | 1 | Command direction |
| cmd_addr | output | BUS_ADDR_W (17) | Bus address of the command |
| cmd_len | output | 7 | Byte count of the command |
| cmd_wdata | output | 8 | Byte value for window register writes |

## Verification
The bench builds the block with its default parameters: a 15-bit window offset, a 64-byte chunk cap and 16-bit lengths. Starting a transfer a few bytes below a window edge makes the boundary split and the following window update visible with short transfers. A 300-byte transfer reaches the 64-byte cap several times in a row and ends with a short tail. A throttled `cmd_ready` pattern checks that back-to-back window writes and held commands survive stalls.

// File: rtl/window_split_pkg.sv
// Shared types of the windowed backplane splitter.
// Assumes: nothing beyond the enclosing design's clocking.
package window_split_pkg;

    // Sequencer phases: idle, window diff capture, window writes, data command.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WIN   = 2'd2,
        ST_DATA  = 2'd3
    } split_state_e;

endpackage

// File: rtl/window_chunker.sv
// Chunk length calculator: smallest of the bytes remaining, the chunk cap,
// and the room left before the next window edge.
// Assumes MAX_CHUNK <= 2**WIN_BITS; purely combinational.
module window_chunker #(
    parameter int WIN_BITS  = 15,
    parameter int LEN_W     = 16,
    parameter int MAX_CHUNK = 64,
    localparam int CHUNK_W  = $clog2(MAX_CHUNK + 1)
) (
    input  logic [WIN_BITS-1:0] offset_i,
    input  logic [LEN_W-1:0]    remain_i,
    output logic [CHUNK_W-1:0]  chunk_o
);
    localparam int MW = (LEN_W > WIN_BITS + 1) ? LEN_W : WIN_BITS + 1;
    localparam logic [MW-1:0] WIN_SIZE = MW'(1) << WIN_BITS;
    localparam logic [MW-1:0] CAP      = MW'(MAX_CHUNK);

    logic [MW-1:0] win_left;
    logic [MW-1:0] rem_w;
    logic [MW-1:0] first_pick;
    logic [MW-1:0] pick;

    // Pick the tightest of the three limits.
    always_comb begin
        win_left   = WIN_SIZE - MW'(offset_i);
        rem_w      = MW'(remain_i);
        first_pick = (rem_w < CAP) ? rem_w : CAP;
        pick       = (win_left < first_pick) ? win_left : first_pick;
        chunk_o    = CHUNK_W'(pick);
    end
endmodule

// File: rtl/window_cache.sv
// Window base cache with lazy byte updates.
// On start_i it compares the three upper base bytes with the cache and marks
// the differing ones pending; pending bytes are presented highest first, one
// per accepted command; the cache takes the new base when the last one is done.
// Assumes start_i and ack_i are never high together.
module window_cache #(
    parameter int               BUS_ADDR_W = 17,
    parameter logic [23:0]      RESET_BYTES = 24'hAAAAAA,
    parameter logic [BUS_ADDR_W-1:0] REG_LO = 17'h1000A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [23:0]           base_bytes_i,
    input  logic                  start_i,
    input  logic                  ack_i,
    output logic                  pend_any_o,
    output logic [BUS_ADDR_W-1:0] reg_addr_o,
    output logic [7:0]            reg_data_o
);
    logic [23:0] cache_q;
    logic [23:0] tgt_q;
    logic [2:0]  pend_q;
    logic [2:0]  diff;
    logic [1:0]  sel;
    logic [2:0]  pend_after;

    // Per-byte difference between the requested base and the cache.
    for (genvar g = 0; g < 3; g++) begin : g_diff
        assign diff[g] = base_bytes_i[8*g +: 8] != cache_q[8*g +: 8];
    end

    // Highest pending byte goes first.
    always_comb begin
        if (pend_q[2])      sel = 2'd2;
        else if (pend_q[1]) sel = 2'd1;
        else                sel = 2'd0;
        pend_after = pend_q & ~(3'b001 << sel);
        reg_addr_o = REG_LO + BUS_ADDR_W'(sel);
        reg_data_o = tgt_q[8*sel +: 8];
        pend_any_o = |pend_q;
    end

    // Capture the diff, retire bytes, commit the new base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_q <= RESET_BYTES;
            tgt_q   <= '0;
            pend_q  <= '0;
        end else if (start_i) begin
            tgt_q  <= base_bytes_i;
            pend_q <= diff;
        end else if (ack_i && pend_any_o) begin
            pend_q <= pend_after;
            if (pend_after == 3'b000) cache_q <= tgt_q;
        end
    end

    // R2: each accepted window write retires exactly one pending byte.
    a_r2_one_byte_per_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pend_any_o) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/window_split.sv
// Windowed backplane access splitter (top).
// Accepts one request at a time, updates the window base registers that
// changed, then emits one data command per chunk until the request is done.
// Assumes BUS_ADDR_W > WIN_BITS and WIN_BITS >= 8; data bytes bypass this block.
module window_split
    import window_split_pkg::*;
#(
    parameter int WIN_BITS   = 15,
    parameter int LEN_W      = 16,
    parameter int MAX_CHUNK  = 64,
    parameter int BUS_ADDR_W = 17,
    parameter logic [31:0] RESET_BASE = 32'hAAAA_AAAA,
    parameter logic [BUS_ADDR_W-1:0] WIN_REG_LO = 17'h1000A,
    localparam int CHUNK_W = $clog2(MAX_CHUNK + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [31:0]           req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_write,
    input  logic                  req_bulk,
    output logic                  req_err,
    output logic                  busy,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic                  cmd_write,
    output logic [BUS_ADDR_W-1:0] cmd_addr,
    output logic [CHUNK_W-1:0]    cmd_len,
    output logic [7:0]            cmd_wdata
);
    localparam logic [31:0] WIN_MASK = (32'd1 << WIN_BITS) - 32'd1;

    split_state_e          state_q;
    logic [31:0]           addr_q;
    logic [LEN_W-1:0]      rem_q;
    logic                  wr_q;
    logic                  flag_q;
    logic                  err_q;

    logic [WIN_BITS-1:0]   offset;
    logic [23:0]           base_bytes;
    logic [CHUNK_W-1:0]    chunk;
    logic                  pend_any;
    logic [BUS_ADDR_W-1:0] reg_addr;
    logic [7:0]            reg_data;
    logic [BUS_ADDR_W-1:0] data_addr;
    logic                  win_ack;

    assign offset     = addr_q[WIN_BITS-1:0];
    assign base_bytes = addr_q[31:8] & ~WIN_MASK[31:8];
    assign win_ack    = (state_q == ST_WIN) && cmd_valid && cmd_ready;

    window_chunker #(
        .WIN_BITS (WIN_BITS),
        .LEN_W    (LEN_W),
        .MAX_CHUNK(MAX_CHUNK)
    ) u_chunker (
        .offset_i (offset),
        .remain_i (rem_q),
        .chunk_o  (chunk)
    );

    window_cache #(
        .BUS_ADDR_W (BUS_ADDR_W),
        .RESET_BYTES(RESET_BASE[31:8]),
        .REG_LO     (WIN_REG_LO)
    ) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_bytes_i(base_bytes),
        .start_i     (state_q == ST_SETUP),
        .ack_i       (win_ack),
        .pend_any_o  (pend_any),
        .reg_addr_o  (reg_addr),
        .reg_data_o  (reg_data)
    );

    // Data command address: offset plus the 32-bit access flag above it.
    always_comb begin
        data_addr              = '0;
        data_addr[WIN_BITS-1:0] = offset;
        data_addr[WIN_BITS]     = flag_q;
    end

    // Command mux: window register write or chunk data command.
    always_comb begin
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_addr  = '0;
        cmd_len   = '0;
        cmd_wdata = '0;
        if (state_q == ST_WIN) begin
            cmd_valid = pend_any;
            cmd_write = 1'b1;
            cmd_addr  = reg_addr;
            cmd_len   = CHUNK_W'(1);
            cmd_wdata = reg_data;
        end else if (state_q == ST_DATA) begin
            cmd_valid = 1'b1;
            cmd_write = wr_q;
            cmd_addr  = data_addr;
            cmd_len   = chunk;
        end
    end

    // Request sequencer: accept, window update, chunk loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            wr_q    <= 1'b0;
            flag_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid && req_len != '0) begin
                        if (req_bulk && req_addr[1:0] != 2'b00) begin
                            err_q <= 1'b1;
                        end else begin
                            addr_q  <= req_addr;
                            rem_q   <= req_len;
                            wr_q    <= req_write;
                            flag_q  <= !req_bulk && (req_len == LEN_W'(4));
                            state_q <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: state_q <= ST_WIN;
                ST_WIN: begin
                    if (!pend_any) state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (cmd_ready) begin
                        if (rem_q == LEN_W'(chunk)) begin
                            state_q <= ST_IDLE;
                        end else begin
                            addr_q  <= addr_q + 32'(chunk);
                            rem_q   <= rem_q - LEN_W'(chunk);
                            state_q <= ST_SETUP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign req_ready = (state_q == ST_IDLE);
    assign req_err   = err_q;

    // R8: a stalled command keeps every field.
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
                                       && $stable(cmd_write) && $stable(cmd_wdata)));

    // R4: a data chunk is nonempty, capped, and stays inside its window.
    a_r4_chunk_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (chunk != '0 && int'(chunk) <= MAX_CHUNK
                                  && int'(offset) + int'(chunk) <= (1 << WIN_BITS)));

    // R6: a rejected request leaves the block idle with no command.
    a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!busy && !cmd_valid));

    // R7: busy only ends right after a data command was taken.
    a_r7_busy_ends_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(state_q == ST_DATA && cmd_ready));
endmodule

// File: tb/window_split_bench.sv
`timescale 1ns/1ps
module window_split_bench;
    localparam int LEN_W   = 16;
    localparam int CHUNK_W = 7;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [31:0]        req_addr = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic               req_write = 1'b0;
    logic               req_bulk = 1'b0;
    logic               req_err;
    logic               busy;
    logic               cmd_valid;
    logic               cmd_ready = 1'b0;
    logic               cmd_write;
    logic [16:0]        cmd_addr;
    logic [CHUNK_W-1:0] cmd_len;
    logic [7:0]         cmd_wdata;

    always #2.5 clk = ~clk;

    window_split u_window_split (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .req_write(req_write), .req_bulk(req_bulk),
        .req_err(req_err), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_wdata(cmd_wdata)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit stall_en = 1'b0;
    int stall_cnt = 0;

    // packed command: {write, addr[16:0], len[6:0], wdata[7:0]}
    logic [32:0] got_cmd [0:127];
    int          got_n = 0;
    logic [32:0] exp_cmd [0:127];
    int          exp_n = 0;
    logic [31:0] m_cache = 32'hAAAA_AAAA;

    // Drive cmd_ready, then record the handshake the next edge will take.
    always @(negedge clk) begin
        cycles++;
        stall_cnt++;
        cmd_ready = stall_en ? (stall_cnt % 3 == 0) : 1'b1;
        if (rst_n && cmd_valid && cmd_ready && got_n < 128) begin
            got_cmd[got_n] = {cmd_write, cmd_addr, cmd_len, cmd_wdata};
            got_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic w, input logic [16:0] a, input logic [6:0] l, input logic [7:0] d);
        exp_cmd[exp_n] = {w, a, l, d};
        exp_n++;
    endtask

    // Expected command list from the requirements (window bytes, chunking, flag).
    task automatic model(input logic [31:0] a, input int len, input bit wr, input bit bulk);
        int rem;
        int off;
        int c;
        logic [31:0] cur;
        logic [31:0] base;
        rem = len;
        cur = a;
        exp_n = 0;
        if (len == 0 || (bulk && a[1:0] != 2'b00)) return;
        while (rem > 0) begin
            base = cur & 32'hFFFF_8000;
            for (int k = 3; k >= 1; k--) begin
                if (base[8*k+7 -: 8] != m_cache[8*k+7 -: 8])
                    push(1'b1, 17'h1000A + 17'(k - 1), 7'd1, base[8*k+7 -: 8]);
            end
            m_cache = base;
            off = int'(cur & 32'h7FFF);
            c = rem;
            if (c > 64) c = 64;
            if (c > 32'h8000 - off) c = 32'h8000 - off;
            push(wr, 17'(off) | ((!bulk && len == 4) ? 17'h8000 : 17'h0), 7'(c), 8'h00);
            cur = cur + 32'(c);
            rem = rem - c;
        end
    endtask

    task automatic compare(input string req);
        check(got_n == exp_n, req, "command count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got_cmd[i] === exp_cmd[i], req, $sformatf("command %0d {wr,addr,len,data}", i),
                  got_cmd[i], exp_cmd[i]);
    endtask

    // Issue one request, wait for completion, compare the command list.
    task automatic run_req(input logic [31:0] a, input int len, input bit wr, input bit bulk,
                           input string req);
        int t;
        model(a, len, wr, bulk);
        @(negedge clk);
        got_n = 0;
        req_valid = 1'b1; req_addr = a; req_len = LEN_W'(len);
        req_write = wr;   req_bulk = bulk;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_n > 0) check(busy == 1'b1, "R7", "busy after accept", busy, 1);
        t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(busy == 1'b0 && req_ready == 1'b1, "R7", "idle at end", busy, 0);
        @(negedge clk);
        compare(req);
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
    endtask

    // R1 R2 R3: first access rewrites all three bytes, high to low.
    task automatic t_first_access;
        run_req(32'h1800_0000, 1, 1'b0, 1'b0, "R1");
        check(exp_n == 4, "R2", "model expects three window writes", exp_n, 4);
    endtask

    // R5: single 4-byte access in the cached window carries the flag.
    task automatic t_single_word;
        run_req(32'h1800_0004, 4, 1'b1, 1'b0, "R5");
    endtask

    // R2: only the low window byte changes.
    task automatic t_low_byte_only;
        run_req(32'h1800_8000, 2, 1'b0, 1'b0, "R2");
    endtask

    // R6: single accesses may be unaligned.
    task automatic t_unaligned_single;
        run_req(32'h1800_8003, 1, 1'b0, 1'b0, "R6");
        check(req_err == 1'b0, "R6", "no error on single", req_err, 0);
    endtask

    // R4 R2: bulk starting below a window edge splits there, then updates low byte.
    task automatic t_boundary_bulk;
        run_req(32'h1800_7FF0, 100, 1'b1, 1'b1, "R4");
    endtask

    // R5: bulk 4-byte transfer never carries the flag.
    task automatic t_bulk_word;
        run_req(32'h1800_0100, 4, 1'b0, 1'b1, "R5");
    endtask

    // R6: misaligned bulk is rejected with a one-cycle pulse and no commands.
    task automatic t_misaligned;
        @(negedge clk);
        got_n = 0;
        req_valid = 1'b1; req_addr = 32'h1800_0002; req_len = 16'd8;
        req_write = 1'b1; req_bulk = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b1, "R6", "error pulse", req_err, 1);
        check(busy == 1'b0, "R6", "busy stays low", busy, 0);
        @(negedge clk);
        check(req_err == 1'b0, "R6", "pulse is one cycle", req_err, 0);
        check(got_n == 0, "R6", "no commands", got_n, 0);
    endtask

    // R9: zero length does nothing.
    task automatic t_zero_len;
        @(negedge clk);
        got_n = 0;
        req_valid = 1'b1; req_addr = 32'h2000_0000; req_len = '0;
        req_write = 1'b0; req_bulk = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b0, "R9", "busy stays low", busy, 0);
        repeat (3) @(negedge clk);
        check(got_n == 0, "R9", "no commands", got_n, 0);
    endtask

    // R8 R4 R2: long transfer in a new window under a throttled ready.
    task automatic t_stalled_long;
        stall_en = 1'b1;
        run_req(32'h1801_0000, 300, 1'b1, 1'b1, "R8");
        stall_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_access();
        t_single_word();
        t_low_byte_only();
        t_unaligned_single();
        t_boundary_bulk();
        t_bulk_word();
        t_misaligned();
        t_zero_len();
        t_stalled_long();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule